// File: doc/BRIEF.md
# Indexed Configuration Byte Port

This block is a bank of 256 byte-wide configuration registers that a host reaches through only two byte addresses. A write to the first address picks a register by loading an 8-bit index. A read or write at the second address then reaches the register that index names. Most of the index space is fixed and keeps its reset value no matter what is written to it. A scattered set of indices in the upper range is writable, and a few of these come up from reset with non-zero values.

Two of the writable registers set where the two serial channels sit in the I/O space. Only one value is legal for each. Whenever either holds anything else, a flag output is raised so that system logic can notice the setting. A decode-enable input, driven from one bit of the parent bridge's configuration, decides whether the port answers the bus at all. While it is low, writes change nothing and reads return all ones.

Top module: `sio_cfg_port`

## Requirements
- R1: With decode enabled, a write with `busAddr`=0 loads `busWdata` into the index. This is the only way the index changes.
- R2: With decode enabled, a write with `busAddr`=1 stores `busWdata` into the indexed register if that index is writable. The writable indices are 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC. No other register changes.
- R3: Every other index (0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF) is write-protected. A data-port write to a protected index leaves its value unchanged.
- R4: Reset sets index 0xE0 to 0x3C, 0xE2 to 0x03, 0xE3 to 0xFC, 0xE6 to 0xDE, 0xE7 to 0xFE and 0xE8 to 0xBE. Every other register, and the index itself, resets to 0x00.
- R5: `unsupFlag` is high exactly while register 0xE7 differs from 0xFE or register 0xE8 differs from 0xBE. It follows a data-port write in the cycle after the write edge, and it is low after reset.
- R6: While `decodeEn` is low, writes at either address change neither the index nor any register, and `busRdata` is 0xFF.
- R7: With decode enabled and `busRd` high, `busRdata` shows the indexed register in the same cycle at either address, and the read has no side effects. With decode enabled and `busRd` low, `busRdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| decodeEn | input | 1 | Port answers bus cycles only while high |
| busAddr | input | 1 | 0 = index address, 1 = data address |
| busWr | input | 1 | Write strobe, taken at the clock edge |
| busRd | input | 1 | Read strobe, combinational read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| unsupFlag | output | 1 | Serial base register holds an unsupported value |

## Verification
A corrupted index register shows up at the next data-port read, because every byte then comes from the wrong slot. That is why the bench reloads the index before each read and compares the whole reset image. A protection map that is too loose shows up only on the read after a write to a protected slot. A map that is too strict shows up as a writable slot that keeps its old byte. Mistakes in the serial-base compare show up on `unsupFlag` in the cycle after the offending write. Leaks through the disable gate show up after decode is enabled again, as a moved index or a changed byte.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [IDX_W-1:0]  SER0_IDX = 8'hE7;
  localparam logic [DATA_W-1:0] SER0_OK  = 8'hFE;
  localparam logic [IDX_W-1:0]  SER1_IDX = 8'hE8;
  localparam logic [DATA_W-1:0] SER1_OK  = 8'hBE;

  // Strobes from control to datapath, one bus cycle each.
  typedef struct packed {
    logic portOpen;
    logic idxLoad;
    logic dataWrite;
    logic dataRead;
  } sioStrobe_t;

  function automatic logic idxWritable(input logic [IDX_W-1:0] idx);
    logic locked;
    locked = idx inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED],
                         8'hF3, 8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]};
    return !locked;
  endfunction

  function automatic logic [DATA_W-1:0] resetByte(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      SER0_IDX: v = SER0_OK;
      SER1_IDX: v = SER1_OK;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
(
  input  logic       decodeEn,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  output sioStrobe_t strobe
);

  always_comb begin
    strobe.portOpen  = decodeEn;
    strobe.idxLoad   = decodeEn && busWr && !busAddr;
    strobe.dataWrite = decodeEn && busWr &&  busAddr;
    strobe.dataRead  = decodeEn && busRd;
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [IDX_W-1:0]  curIdx,
  output logic [DATA_W-1:0] selByte,
  output logic [DATA_W-1:0] rdata,
  output logic              unsupFlag
);

  localparam logic [DATA_W-1:0] IDLE_OPEN   = '0;
  localparam logic [DATA_W-1:0] IDLE_CLOSED = '1;

  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] entryBus [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idxQ <= '0;
    else if (strobe.idxLoad) idxQ <= wdata[IDX_W-1:0];
  end

  // One slot per index; the protection map picks a flop or a constant.
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam logic [IDX_W-1:0] G_IDX = IDX_W'(g);
    if (idxWritable(G_IDX)) begin : gRw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                  q <= resetByte(G_IDX);
        else if (strobe.dataWrite && idxQ == G_IDX) q <= wdata;
      end
      assign entryBus[g] = q;
    end else begin : gRo
      assign entryBus[g] = resetByte(G_IDX);
    end
  end

  assign curIdx  = idxQ;
  assign selByte = entryBus[idxQ];

  always_comb begin
    if (!strobe.portOpen)     rdata = IDLE_CLOSED;
    else if (strobe.dataRead) rdata = selByte;
    else                      rdata = IDLE_OPEN;
  end

  assign unsupFlag = (entryBus[SER0_IDX] != SER0_OK) ||
                     (entryBus[SER1_IDX] != SER1_OK);

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              decodeEn,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              unsupFlag
);

  sioStrobe_t        strobe;
  logic [IDX_W-1:0]  curIdx;
  logic [DATA_W-1:0] selByte;

  sio_cfg_ctrl i_ctrl (
    .decodeEn (decodeEn),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .strobe   (strobe)
  );

  sio_cfg_regs i_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wdata     (busWdata),
    .curIdx    (curIdx),
    .selByte   (selByte),
    .rdata     (busRdata),
    .unsupFlag (unsupFlag)
  );

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              decodeEn,
  input logic              busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              unsupFlag,
  input logic [IDX_W-1:0]  curIdx,
  input logic [DATA_W-1:0] selByte
);

  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busWr && !busAddr) |=> curIdx == $past(busWdata));

  assert_idx_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(decodeEn && busWr && !busAddr) |=> $stable(curIdx));

  assert_rw_take_R2: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busWr && busAddr && idxWritable(curIdx)) |=> selByte == $past(busWdata));

  assert_ro_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busWr && busAddr && !idxWritable(curIdx)) |=> $stable(selByte));

  assert_ser0_bad_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busWr && busAddr && curIdx == SER0_IDX && busWdata != SER0_OK) |=> unsupFlag);

  assert_ser1_bad_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busWr && busAddr && curIdx == SER1_IDX && busWdata != SER1_OK) |=> unsupFlag);

  assert_closed_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !decodeEn |=> ($stable(curIdx) && $stable(selByte)));

  assert_closed_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    !decodeEn |-> busRdata == '1);

  assert_open_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decodeEn && busRd) |-> busRdata == selByte);

endmodule

bind sio_cfg_port sio_cfg_port_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .decodeEn  (decodeEn),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .unsupFlag (unsupFlag),
  .curIdx    (curIdx),
  .selByte   (selByte)
);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decodeEn = 1'b0;
  logic       busAddr = 1'b0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       unsupFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk       (clk),
    .rstN      (rstN),
    .decodeEn  (decodeEn),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .unsupFlag (unsupFlag)
  );

  // Expected model, written from the requirements.
  function automatic logic [7:0] expReset(input logic [7:0] idx);
    case (idx)
      8'hE0: return 8'h3C;
      8'hE2: return 8'h03;
      8'hE3: return 8'hFC;
      8'hE6: return 8'hDE;
      8'hE7: return 8'hFE;
      8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] data);
    @(negedge clk);
    busAddr = addr; busRd = 1'b1;
    #1 data = busRdata;
    busRd = 1'b0;
  endtask

  task automatic readIdx(input logic [7:0] idx, output logic [7:0] data);
    busWrite(1'b0, idx);
    busRead(1'b1, data);
  endtask

  task automatic testReset();
    logic [7:0] v;
    #1;
    check("R6 closed read 0xFF during reset", busRdata, 8'hFF);
    check("R5 flag low after reset", {7'd0, unsupFlag}, 8'h00);
    decodeEn = 1'b1;
    busRead(1'b1, v);
    check("R4 index reset points at 0x00", v, 8'h00);
    for (int i = 0; i < 256; i++) begin
      readIdx(8'(i), v);
      check($sformatf("R4 reset image idx %h", i), v, expReset(8'(i)));
    end
  endtask

  task automatic testProtected();
    logic [7:0] v;
    logic [7:0] locked [14] = '{8'h00, 8'h5A, 8'hDF, 8'hE4, 8'hE5, 8'hE9, 8'hED,
                                 8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFB, 8'hFD, 8'hFF};
    for (int i = 0; i < 14; i++) begin
      busWrite(1'b0, locked[i]);
      busWrite(1'b1, 8'hA5);
      busRead(1'b1, v);
      check($sformatf("R3 protected idx %h kept", locked[i]), v, expReset(locked[i]));
    end
  endtask

  task automatic testWritable();
    logic [7:0] v;
    logic [7:0] slot [6] = '{8'hE1, 8'hEE, 8'hFC, 8'hE0, 8'hF2, 8'hF8};
    logic [7:0] val  [6] = '{8'h5A, 8'h33, 8'h77, 8'hC3, 8'h81, 8'h0F};
    for (int i = 0; i < 6; i++) begin
      busWrite(1'b0, slot[i]);
      busWrite(1'b1, val[i]);
    end
    for (int i = 0; i < 6; i++) begin
      readIdx(slot[i], v);
      check($sformatf("R2 writable idx %h", slot[i]), v, val[i]);
    end
    readIdx(8'hE2, v);
    check("R2 neighbour 0xE2 untouched", v, 8'h03);
    readIdx(8'hE3, v);
    check("R1 index selects 0xE3", v, 8'hFC);
  endtask

  task automatic testUnsupported();
    logic [7:0] v;
    busWrite(1'b0, 8'hE7);
    busWrite(1'b1, 8'h12);
    check("R5 flag on bad 0xE7", {7'd0, unsupFlag}, 8'h01);
    busRead(1'b1, v);
    check("R2 0xE7 stores bad value", v, 8'h12);
    busWrite(1'b1, 8'hFE);
    check("R5 flag clears with 0xE7=FE", {7'd0, unsupFlag}, 8'h00);
    busWrite(1'b0, 8'hE8);
    busWrite(1'b1, 8'h00);
    check("R5 flag on bad 0xE8", {7'd0, unsupFlag}, 8'h01);
    busWrite(1'b1, 8'hBE);
    check("R5 flag clears with 0xE8=BE", {7'd0, unsupFlag}, 8'h00);
  endtask

  task automatic testDisabled();
    logic [7:0] v;
    busWrite(1'b0, 8'hE1);
    @(negedge clk);
    decodeEn = 1'b0;
    busRead(1'b1, v);
    check("R6 closed data read 0xFF", v, 8'hFF);
    busRead(1'b0, v);
    check("R6 closed index read 0xFF", v, 8'hFF);
    busWrite(1'b1, 8'h99);
    busWrite(1'b0, 8'hE6);
    busWrite(1'b1, 8'h44);
    @(negedge clk);
    decodeEn = 1'b1;
    busRead(1'b1, v);
    check("R6 closed writes left index and 0xE1", v, 8'h5A);
    readIdx(8'hE6, v);
    check("R6 closed write left 0xE6", v, 8'hDE);
  endtask

  task automatic testRead();
    logic [7:0] v;
    busWrite(1'b0, 8'hEE);
    busRead(1'b1, v);
    check("R7 data read first", v, 8'h33);
    busRead(1'b1, v);
    check("R7 repeat read unchanged", v, 8'h33);
    busRead(1'b0, v);
    check("R7 read at index address", v, 8'h33);
    @(negedge clk);
    #1 check("R7 no read strobe gives 0x00", busRdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testProtected();
    testWritable();
    testUnsupported();
    testDisabled();
    testRead();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule